// File: doc/BRIEF.md
# Constant-Time Modular Exponentiation Sequencer

This block computes g^e mod m by driving an external Montgomery multiplier through a request/acknowledge interface. It takes the base, the exponent, the odd modulus and two precomputed constants: the Montgomery radix reduced mod m (the domain form of 1) and the square of the radix reduced mod m. The block itself does no multiplication. It orders the multiplier calls, keeps the accumulator, and finishes with two masked conditional subtractions. The multiplier may return lazily reduced values below 2m.

The exponent width is fixed by a parameter, and every exponent of that width produces the same list of multiplier calls. Leading zero bits are processed like any other bit. The parameter `WIN` picks one of two variants. With `WIN` = 1 the exponent is scanned bit by bit, and each squaring is followed by a multiply whose operand is chosen by a mask: either the domain form of g or the domain form of 1. With `WIN` > 1 the block first fills a table of 2^WIN domain-form powers of g. It then handles each WIN-bit digit of the exponent with WIN squarings and one multiply by the table entry that the digit selects. The default window is 5, which gives a 32-entry table.

Top module: `ctmodexp`

## Requirements
- R1: The first multiplier call after an accepted `start` has operands (`base`, `r2_mod`); its result X is the domain form of g, and the accumulator is then set to `r_mod`.
- R2: The exponent is consumed from its most significant bit down to bit 0, and each bit (binary) or each WIN-bit digit (windowed) starts with squarings, where both operands are the accumulator.
- R3: With `WIN` = 1, every squaring is followed by one multiply of the accumulator by X when the bit is 1 or by `r_mod` when it is 0, so a run makes exactly 2·EBITS+2 calls.
- R4: With `WIN` > 1, 2^WIN−1 calls build table entries i = 1..2^WIN−1 as entry(i−1)·X, entry 0 being `r_mod`; then each digit gets WIN squarings and one multiply by entry[digit], so a run makes 2^WIN + (EBITS/WIN)·(WIN+1) + 1 calls.
- R5: The last multiplier call of a run has second operand 1, which brings the accumulator out of the Montgomery domain.
- R6: The result at `done` is the exit value after two masked subtract-m-if-not-less stages, so it equals g^e mod m and is below `modulus`.
- R7: For a fixed `WIN`, the number of calls, the cycle offsets at which they are issued and the cycle count from `start` to `done` are the same for every exponent, including all-zero and all-one exponents.
- R8: `mm_req` is high only while a run is busy, and while it is high without `mm_ack` the operands `mm_a` and `mm_b` hold steady. `mm_ack` is a one-cycle pulse that carries `mm_res`.
- R9: `busy` rises the cycle after an accepted `start`; `done` is a one-cycle pulse at which `busy` is already low; a `start` that arrives while busy is ignored.
- R10: `result` changes only in the cycle in which `done` is high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only when idle |
| base | input | W | Base g, below modulus |
| expo | input | EBITS | Exponent |
| modulus | input | W | Odd modulus m |
| r_mod | input | W | Montgomery radix mod m (domain form of 1) |
| r2_mod | input | W | Radix squared mod m |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | g^e mod m, valid from done |
| mm_req | output | 1 | Multiplier request, held until acknowledged |
| mm_a | output | W | Multiplier first operand |
| mm_b | output | W | Multiplier second operand |
| mm_ack | input | 1 | Multiplier result valid, one-cycle pulse |
| mm_res | input | W | Multiplier result a·b·R⁻¹ mod m (may be below 2m) |

## Verification
On every cycle the assertions check the handshake rules: requests occur only while busy, operands hold steady while a request waits, the entry call carries the base and the squared radix, done is a single pulse that ends busy, the result is held between runs and is below the modulus. Only the bench scenarios can show the parts that span a whole run: that the numeric result matches a reference exponentiation, that the call count matches the formula for each variant, and that the call timing signature and the total latency are identical for exponents of 0, 1, all ones and mixed patterns. The last-call operand of 1 and the rejection of a second start are also checked per scenario.

// File: rtl/ctme_pkg.sv
package ctme_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ENTER,
      ST_BUILD,
      ST_SQR,
      ST_MUL,
      ST_EXIT,
      ST_REDUCE
   } ctme_state_t;
endpackage

// File: rtl/ctme_digit_scan.sv
module ctme_digit_scan #(
   parameter int EBITS = 20,
   parameter int WIN   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [EBITS-1:0] expo,
   input  logic             advance,
   output logic [WIN-1:0]   digit,
   output logic             last_win
);
   localparam int NWIN = EBITS / WIN;
   localparam int CW   = $clog2(NWIN + 1);

   logic [EBITS-1:0] e_q;
   logic [CW-1:0]    wc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_q  <= '0;
         wc_q <= '0;
      end else if (load) begin
         e_q  <= expo;
         wc_q <= '0;
      end else if (advance) begin
         e_q  <= e_q << WIN;
         wc_q <= wc_q + 1'b1;
      end
   end

   assign digit    = e_q[EBITS-1 -: WIN];
   assign last_win = (wc_q == CW'(NWIN - 1));
endmodule

// File: rtl/ctme_operand_sel.sv
module ctme_operand_sel #(
   parameter int W   = 16,
   parameter int WIN = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic           wr_first,
   input  logic [W-1:0]   wr_data,
   input  logic [W-1:0]   one_val,
   input  logic [WIN-1:0] digit,
   output logic [W-1:0]   mul_op,
   output logic [W-1:0]   build_a,
   output logic [W-1:0]   build_b,
   output logic           build_last
);
   logic [W-1:0] x_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                x_r <= '0;
      else if (wr_en && wr_first) x_r <= wr_data;
   end

   assign build_b = x_r;

   if (WIN == 1) begin : g_mask
      logic [W-1:0] mask;
      assign mask       = {W{digit[0]}};
      assign mul_op     = (x_r & mask) | (one_val & ~mask);
      assign build_a    = x_r;
      assign build_last = 1'b1;
   end else begin : g_table
      localparam int TSIZE = 1 << WIN;
      logic [W-1:0]   tbl [TSIZE];
      logic [WIN-1:0] wp_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp_q <= '0;
         end else if (wr_en && wr_first) begin
            wp_q <= WIN'(1);
         end else if (wr_en) begin
            wp_q <= wp_q + 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (wr_en && wr_first)
            tbl[0] <= one_val;
         else if (wr_en)
            tbl[wp_q] <= wr_data;
      end

      assign mul_op     = tbl[digit];
      assign build_a    = tbl[wp_q - 1'b1];
      assign build_last = (wp_q == WIN'(TSIZE - 1));
   end
endmodule

// File: rtl/ctme_reduce.sv
module ctme_reduce #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] m,
   output logic [W-1:0] y
);
   logic [W-1:0] chain [STAGES+1];
   assign chain[0] = x;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W:0]   diff;
      logic [W-1:0] keep_mask;
      assign diff      = {1'b0, chain[s]} - {1'b0, m};
      assign keep_mask = {W{diff[W]}};
      assign chain[s+1] = (chain[s] & keep_mask) | (diff[W-1:0] & ~keep_mask);
   end

   assign y = chain[STAGES];
endmodule

// File: rtl/ctmodexp.sv
module ctmodexp #(
   parameter int W     = 16,
   parameter int EBITS = 20,
   parameter int WIN   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [W-1:0]     base,
   input  logic [EBITS-1:0] expo,
   input  logic [W-1:0]     modulus,
   input  logic [W-1:0]     r_mod,
   input  logic [W-1:0]     r2_mod,
   output logic             busy,
   output logic             done,
   output logic [W-1:0]     result,
   output logic             mm_req,
   output logic [W-1:0]     mm_a,
   output logic [W-1:0]     mm_b,
   input  logic             mm_ack,
   input  logic [W-1:0]     mm_res
);
   import ctme_pkg::*;

   localparam int SQW = (WIN > 1) ? $clog2(WIN) : 1;

   if (W < 2) begin : g_bad_w
      $error("ctmodexp: W must be at least 2");
   end
   if (WIN < 1 || WIN > 8) begin : g_bad_win
      $error("ctmodexp: WIN must lie in 1..8");
   end
   if (EBITS % WIN != 0 || EBITS < WIN) begin : g_bad_ebits
      $error("ctmodexp: EBITS must be a non-zero multiple of WIN");
   end

   ctme_state_t    st_q;
   logic [W-1:0]   acc_q, g_q, r2_q, one_q, m_q;
   logic [SQW-1:0] sq_q;
   logic           accept, wr_en, wr_first, advance;
   logic [WIN-1:0] digit;
   logic           last_win, build_last;
   logic [W-1:0]   mul_op, build_a, build_b, reduced;

   assign accept   = start && (st_q == ST_IDLE);
   assign wr_first = (st_q == ST_ENTER);
   assign wr_en    = mm_ack && (st_q == ST_ENTER || st_q == ST_BUILD);
   assign advance  = mm_ack && (st_q == ST_MUL);

   ctme_digit_scan #(.EBITS(EBITS), .WIN(WIN)) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .expo     (expo),
      .advance  (advance),
      .digit    (digit),
      .last_win (last_win)
   );

   ctme_operand_sel #(.W(W), .WIN(WIN)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_first   (wr_first),
      .wr_data    (mm_res),
      .one_val    (one_q),
      .digit      (digit),
      .mul_op     (mul_op),
      .build_a    (build_a),
      .build_b    (build_b),
      .build_last (build_last)
   );

   ctme_reduce #(.W(W), .STAGES(2)) u_red (
      .x (acc_q),
      .m (m_q),
      .y (reduced)
   );

   always_comb begin
      mm_req = 1'b1;
      mm_a   = acc_q;
      mm_b   = acc_q;
      unique case (st_q)
         ST_ENTER: begin mm_a = g_q;     mm_b = r2_q;    end
         ST_BUILD: begin mm_a = build_a; mm_b = build_b; end
         ST_SQR:   begin mm_a = acc_q;   mm_b = acc_q;   end
         ST_MUL:   begin mm_a = acc_q;   mm_b = mul_op;  end
         ST_EXIT:  begin mm_a = acc_q;   mm_b = W'(1);   end
         default:  begin mm_req = 1'b0;  mm_a = '0; mm_b = '0; end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         acc_q  <= '0;
         g_q    <= '0;
         r2_q   <= '0;
         one_q  <= '0;
         m_q    <= '0;
         sq_q   <= '0;
         busy   <= 1'b0;
         done   <= 1'b0;
         result <= '0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (accept) begin
               g_q   <= base;
               r2_q  <= r2_mod;
               one_q <= r_mod;
               m_q   <= modulus;
               busy  <= 1'b1;
               st_q  <= ST_ENTER;
            end
            ST_ENTER: if (mm_ack) begin
               acc_q <= one_q;
               sq_q  <= '0;
               st_q  <= (WIN > 1) ? ST_BUILD : ST_SQR;
            end
            ST_BUILD: if (mm_ack && build_last) begin
               st_q <= ST_SQR;
            end
            ST_SQR: if (mm_ack) begin
               acc_q <= mm_res;
               if (sq_q == SQW'(WIN - 1)) begin
                  sq_q <= '0;
                  st_q <= ST_MUL;
               end else begin
                  sq_q <= sq_q + 1'b1;
               end
            end
            ST_MUL: if (mm_ack) begin
               acc_q <= mm_res;
               st_q  <= last_win ? ST_EXIT : ST_SQR;
            end
            ST_EXIT: if (mm_ack) begin
               acc_q <= mm_res;
               st_q  <= ST_REDUCE;
            end
            ST_REDUCE: begin
               result <= reduced;
               done   <= 1'b1;
               busy   <= 1'b0;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ctmodexp_chk.sv
module ctmodexp_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic [W-1:0] result,
   input logic [W-1:0] modulus,
   input logic [W-1:0] base,
   input logic [W-1:0] r2_mod,
   input logic         mm_req,
   input logic [W-1:0] mm_a,
   input logic [W-1:0] mm_b,
   input logic         mm_ack
);
   AST_ENTRY_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (mm_req && mm_a == $past(base) && mm_b == $past(r2_mod))); // R1
   AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mm_req); // R8
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mm_req && !mm_ack) |=> (mm_req && $stable(mm_a) && $stable(mm_b))); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R9
   AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy); // R9
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result)); // R10
   AST_RESULT_BELOW_M: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (result < modulus)); // R6
endmodule

bind ctmodexp ctmodexp_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .result  (result),
   .modulus (modulus),
   .base    (base),
   .r2_mod  (r2_mod),
   .mm_req  (mm_req),
   .mm_a    (mm_a),
   .mm_b    (mm_b),
   .mm_ack  (mm_ack)
);

// File: tb/ctmodexp_test.sv
module mm_model #(
   parameter int W   = 16,
   parameter int RB  = 16,
   parameter int LAT = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         req,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] m,
   output logic         ack,
   output logic [W-1:0] res,
   output int           ops,
   output longint       sig,
   output logic [W-1:0] first_a,
   output logic [W-1:0] first_b,
   output logic [W-1:0] last_b
);
   logic         busy_q;
   int           cnt, cyc;
   logic [W-1:0] a_q, b_q;

   function automatic logic [W-1:0] mont(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic [W-1:0] mm);
      logic [W+2:0] t;
      t = '0;
      for (int i = 0; i < RB; i++) begin
         if (x[i]) t = t + (W+3)'(y);
         if (t[0]) t = t + (W+3)'(mm);
         t = t >> 1;
      end
      return t[W-1:0];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0; ack <= 1'b0; res <= '0; cnt <= 0; cyc <= 0;
         ops <= 0; sig <= 0; first_a <= '0; first_b <= '0; last_b <= '0;
         a_q <= '0; b_q <= '0;
      end else begin
         ack <= 1'b0;
         cyc <= cyc + 1;
         if (clr) begin
            ops <= 0; sig <= 0; cyc <= 0;
         end else if (busy_q) begin
            if (cnt == 1) begin
               ack    <= 1'b1;
               res    <= mont(a_q, b_q, m);
               busy_q <= 1'b0;
            end else begin
               cnt <= cnt - 1;
            end
         end else if (req && !ack) begin
            busy_q <= 1'b1;
            cnt    <= LAT;
            a_q    <= a;
            b_q    <= b;
            if (ops == 0) begin first_a <= a; first_b <= b; end
            ops    <= ops + 1;
            sig    <= sig * 31 + longint'(cyc);
            last_b <= b;
         end
      end
   end
endmodule

module ctmodexp_test;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 16;
   localparam int EB = 20;
   localparam int KW = 5;
   localparam int OPS_WIN = (1 << KW) + (EB / KW) * (KW + 1) + 1;
   localparam int OPS_BIN = 2 * EB + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic          start_w = 1'b0, start_b = 1'b0;
   logic [W-1:0]  base = '0, modulus = 16'd1, r_mod = '0, r2_mod = '0;
   logic [EB-1:0] expo = '0;
   logic          clr = 1'b0;

   logic         busy_w, done_w, req_w, ack_w, busy_b, done_b, req_b, ack_b;
   logic [W-1:0] res_w, a_w, b_w, mres_w, res_b, a_b, b_b, mres_b;
   int           ops_w, ops_b;
   longint       sig_w, sig_b;
   logic [W-1:0] fa_w, fb_w, lb_w, fa_b, fb_b, lb_b;

   ctmodexp #(.W(W), .EBITS(EB), .WIN(KW)) uut (
      .clk(clk), .rst_n(rst_n), .start(start_w), .base(base), .expo(expo),
      .modulus(modulus), .r_mod(r_mod), .r2_mod(r2_mod), .busy(busy_w), .done(done_w),
      .result(res_w), .mm_req(req_w), .mm_a(a_w), .mm_b(b_w), .mm_ack(ack_w), .mm_res(mres_w));

   ctmodexp #(.W(W), .EBITS(EB), .WIN(1)) uut_bin (
      .clk(clk), .rst_n(rst_n), .start(start_b), .base(base), .expo(expo),
      .modulus(modulus), .r_mod(r_mod), .r2_mod(r2_mod), .busy(busy_b), .done(done_b),
      .result(res_b), .mm_req(req_b), .mm_a(a_b), .mm_b(b_b), .mm_ack(ack_b), .mm_res(mres_b));

   mm_model #(.W(W), .RB(16), .LAT(3)) mdl_w (
      .clk(clk), .rst_n(rst_n), .clr(clr), .req(req_w), .a(a_w), .b(b_w), .m(modulus),
      .ack(ack_w), .res(mres_w), .ops(ops_w), .sig(sig_w), .first_a(fa_w), .first_b(fb_w),
      .last_b(lb_w));

   mm_model #(.W(W), .RB(16), .LAT(3)) mdl_b (
      .clk(clk), .rst_n(rst_n), .clr(clr), .req(req_b), .a(a_b), .b(b_b), .m(modulus),
      .ack(ack_b), .res(mres_b), .ops(ops_b), .sig(sig_b), .first_a(fa_b), .first_b(fb_b),
      .last_b(lb_b));

   int     total = 0, bad = 0;
   int     ref_cyc [2];
   longint ref_sig [2];
   bit     ref_set [2];

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint ref_pow(input longint g, input logic [EB-1:0] e, input longint m);
      longint r = 1 % m;
      for (int i = EB - 1; i >= 0; i--) begin
         r = (r * r) % m;
         if (e[i]) r = (r * g) % m;
      end
      return r;
   endfunction

   task automatic set_mod(input logic [W-1:0] m);
      longint rr;
      modulus = m;
      rr      = (longint'(1) << 16) % longint'(m);
      r_mod   = W'(rr);
      r2_mod  = W'((rr * rr) % longint'(m));
   endtask

   // one run on either variant; glitch pulses a second start mid-run
   task automatic run_case(input bit bin, input logic [W-1:0] g, input logic [W-1:0] m,
                           input logic [EB-1:0] e, input bit glitch);
      int           cyc, ops, mi;
      longint       sig, expv;
      logic [W-1:0] res, fa, fb, lb;
      bit           dn;
      mi = bin ? 1 : 0;
      @(negedge clk);
      set_mod(m);
      base = g;
      expo = e;
      clr  = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      if (bin) start_b = 1'b1; else start_w = 1'b1;
      @(negedge clk);
      start_b = 1'b0; start_w = 1'b0;
      chk(bin ? busy_b : busy_w, "R9 busy after start", 0, 1);
      cyc = 1;
      dn  = 0;
      while (!dn && cyc < 5000) begin
         if (glitch && cyc == 40) begin
            base = g ^ 16'h0005;
            if (bin) start_b = 1'b1; else start_w = 1'b1;
         end else begin
            start_b = 1'b0; start_w = 1'b0;
         end
         @(negedge clk);
         cyc++;
         dn = bin ? done_b : done_w;
      end
      start_b = 1'b0; start_w = 1'b0;
      res  = bin ? res_b : res_w;
      ops  = bin ? ops_b : ops_w;
      sig  = bin ? sig_b : sig_w;
      fa   = bin ? fa_b : fa_w;
      fb   = bin ? fb_b : fb_w;
      lb   = bin ? lb_b : lb_w;
      expv = ref_pow(longint'(g), e, longint'(m));
      chk(dn, "R9 done reached", cyc, 5000);
      chk(longint'(res) == expv, "R6 result value", res, expv);
      chk(fa == g && fb == r2_mod, "R1 entry operands", {fa, fb}, {g, r2_mod});
      chk(lb == 16'd1, "R5 exit operand", lb, 1);
      if (bin) chk(ops == OPS_BIN, "R3 call count binary", ops, OPS_BIN);
      else     chk(ops == OPS_WIN, "R4 call count windowed", ops, OPS_WIN);
      if (!ref_set[mi]) begin
         ref_set[mi] = 1;
         ref_cyc[mi] = cyc;
         ref_sig[mi] = sig;
      end else begin
         chk(cyc == ref_cyc[mi], "R7 latency constant", cyc, ref_cyc[mi]);
         chk(sig == ref_sig[mi], "R7 call timing signature", sig, ref_sig[mi]);
      end
      @(negedge clk);
      chk((bin ? done_b : done_w) == 1'b0, "R9 done one cycle", 1, 0);
   endtask

   task automatic test_reset;
      chk(!busy_w && !done_w && !req_w, "R8 R9 reset idle windowed", {busy_w, done_w, req_w}, 0);
      chk(!busy_b && !done_b && !req_b, "R8 R9 reset idle binary", {busy_b, done_b, req_b}, 0);
      chk(res_w == 0 && res_b == 0, "R10 reset result", res_w, 0);
   endtask

   task automatic test_patterns(input bit bin);
      run_case(bin, 16'd1234, 16'd9973, 20'h00000, 0);  // R2 all leading zeros
      run_case(bin, 16'd1234, 16'd9973, 20'hFFFFF, 0);  // R2 all ones
      run_case(bin, 16'd7,    16'd9973, 20'h00001, 0);
      run_case(bin, 16'd4321, 16'd9973, 20'hA5C3E, 0);
      run_case(bin, 16'd16000, 16'd16383, 20'h80001, 0); // R6 large modulus
      run_case(bin, 16'd2,    16'd12345, 20'h3F0F1, 1);  // R9 start ignored while busy
   endtask

   task automatic test_hold;
      logic [W-1:0] keep;
      keep = res_w;
      base = 16'd55;
      expo = 20'h12345;
      repeat (10) @(negedge clk);
      chk(res_w == keep, "R10 result held while idle", res_w, keep);
      chk(!req_w, "R8 no request while idle", req_w, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_patterns(0);
      test_hold();
      test_patterns(1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule